// File: doc/BRIEF.md
# One-Time Fuse Array Controller

This block manages a 256-bit one-time-programmable fuse store behind a 32-bit register bus. Software stages up to eight 32-bit program words, then issues a program command. Each program word is OR-ed into the matching fuse word, so a fuse bit can be set but never cleared. The most significant bit of the last fuse word is a lock fuse. Once it is blown, every later program command is refused.

Software never reads the fuses directly. A read command takes a snapshot of all eight fuse words and places it in eight read-only data registers. If one control write requests both operations, the program step happens first, so the snapshot already contains the newly set bits.

The bus accepts only aligned, full-word accesses. Accesses to reserved or unmapped offsets, misaligned accesses and partial accesses are rejected and reported with a one-cycle error pulse. A lock-status output follows the lock fuse.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: While reset is held, and on the first cycle after it, all fuse words, data registers, program words, the timing register and the command bits are zero, and `bus_rdata`, `bus_err` and `lock_status` are 0.
- R2: The bus uses byte offsets. Control is at 0x00, data words 0..7 at 0x08..0x24, program words 0..7 at 0x28..0x44 and timing at 0x7C. A valid read returns the register value on `bus_rdata` in the cycle after the request. `bus_rdata` is 0 in any cycle that follows no valid read.
- R3: The program words and the timing register store any 32-bit value written to them, and read back that value.
- R4: A control write with bit 1 set (program command) ORs every program word into its fuse word on the following clock edge. Fuse bits are never cleared.
- R5: `lock_status` equals bit 31 of fuse word 7. While that bit is 1, a program command leaves all fuse words unchanged.
- R6: A control write with bit 0 set (read command) copies all eight fuse words into the data registers on the following clock edge.
- R7: When bits 0 and 1 are both set in one control write, the snapshot holds the fuse contents after programming.
- R8: Writes to the data registers have no effect.
- R9: The control register reads back bits 1:0 as written during the single cycle before the command executes. They are 0 afterwards. Bits 31:2 always read 0.
- R10: A read or write is invalid if its address has `bus_addr[1:0]` not equal to 0, if `bus_be` is not 4'hF, or if it targets offset 0x04 or 0x48..0x78. An invalid access pulses `bus_err` high in the next cycle, returns 0 on a read, and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 7 | Byte offset within the 0x80 window |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_be | input | 4 | Byte enables; all four must be set |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_err | output | 1 | One-cycle pulse after an invalid access |
| lock_status | output | 1 | Current state of the lock fuse |

## Verification
The bench runs a behavioural model alongside the design and compares the outputs on every clock. It targets the following corner cases:

- **Second program pass.** The bench programs a pattern that leaves earlier fuse bits out. A design that assigns the fuses instead of OR-ing them would show those bits cleared.
- **Combined command.** The bench sets read and program in one write. A design that snapshots before programming would return stale data.
- **Refused program.** After the lock fuse is blown, the bench attempts another program. A design with a missing or inverted lock check would alter the array.
- **Rejected accesses.** Writes to data registers, to reserved words, with partial byte enables and to misaligned addresses are each followed by a read-back. This would expose a write that leaks through, or an error pulse that is missing or appears at the wrong time.

// File: rtl/otp_fuse_pkg.sv
// Shared definitions for the fuse controller: register regions and
// command bit positions in the control word.
package otp_fuse_pkg;

    // Register region selected by a bus offset.
    typedef enum logic [2:0] {
        RG_CTL,
        RG_DAT,
        RG_PGM,
        RG_TIM,
        RG_BAD
    } fuse_region_e;

    // Bit positions of the commands in the control word.
    localparam int CMD_READ_BIT = 0;
    localparam int CMD_PROG_BIT = 1;

endpackage

// File: rtl/otp_addr_decode.sv
// Address decoder for the fuse controller.
// Maps a byte offset onto a register region and a word index, and
// flags accesses that are misaligned, partial or unmapped.
// Assumes the window is 2**AW bytes with the timing word last.
module otp_addr_decode
    import otp_fuse_pkg::*;
#(
    parameter int AW    = 7,
    parameter int DW    = 32,
    parameter int WORDS = 8
) (
    input  logic [AW-1:0]           addr,
    input  logic [DW/8-1:0]         be,
    output fuse_region_e            region,
    output logic [$clog2(WORDS)-1:0] idx,
    output logic                    acc_ok
);
    localparam int WW        = AW - 2;
    localparam int IW        = $clog2(WORDS);
    localparam int WIN_WORDS = 1 << WW;
    localparam int DAT_BASE  = 2;
    localparam int PGM_BASE  = DAT_BASE + WORDS;
    localparam int TIM_WORD  = WIN_WORDS - 1;

    logic [WW-1:0] word;

    // Region and index selection from the word offset.
    always_comb begin
        word   = addr[AW-1:2];
        region = RG_BAD;
        idx    = '0;
        if (word == WW'(0)) begin
            region = RG_CTL;
        end else if (word >= WW'(DAT_BASE) && word < WW'(PGM_BASE)) begin
            region = RG_DAT;
            idx    = IW'(word - WW'(DAT_BASE));
        end else if (word >= WW'(PGM_BASE) && word < WW'(PGM_BASE + WORDS)) begin
            region = RG_PGM;
            idx    = IW'(word - WW'(PGM_BASE));
        end else if (word == WW'(TIM_WORD)) begin
            region = RG_TIM;
        end
    end

    // Only aligned full-word accesses to mapped offsets are accepted.
    always_comb begin
        acc_ok = (addr[1:0] == 2'b00) && (&be) && (region != RG_BAD);
    end
endmodule

// File: rtl/otp_fuse_array.sv
// Behavioural fuse storage.
// Each word can only gain set bits. Programming ORs the staged words in
// unless the lock fuse (top bit of the last word) is set. The value the
// array will hold after this cycle's program step is exported so that a
// snapshot taken in the same cycle sees it.
module otp_fuse_array #(
    parameter int DW    = 32,
    parameter int WORDS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                do_prog,
    input  logic [WORDS*DW-1:0] pgm_flat,
    output logic [WORDS*DW-1:0] fuse_flat,
    output logic [WORDS*DW-1:0] fuse_next,
    output logic                locked
);
    localparam int TOP = WORDS * DW - 1;

    logic prog_en;

    // Lock fuse sits in the top bit of the array.
    always_comb begin
        locked  = fuse_flat[TOP];
        prog_en = do_prog && !locked;
    end

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        // Next value of one fuse word: OR in the staged word when enabled.
        always_comb begin
            fuse_next[w*DW +: DW] = fuse_flat[w*DW +: DW] |
                                    (prog_en ? pgm_flat[w*DW +: DW] : '0);
        end

        // Fuse word register, cleared only by reset.
        always_ff @(posedge clk) begin
            if (!rst_n) fuse_flat[w*DW +: DW] <= '0;
            else        fuse_flat[w*DW +: DW] <= fuse_next[w*DW +: DW];
        end
    end
endmodule

// File: rtl/otp_reg_file.sv
// Register file of the fuse controller: control command bits, staged
// program words, timing word and read-only snapshot registers.
// Assumes wr_en is already qualified by a valid decode.
module otp_reg_file
    import otp_fuse_pkg::*;
#(
    parameter int DW    = 32,
    parameter int WORDS = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  fuse_region_e             region,
    input  logic [$clog2(WORDS)-1:0] idx,
    input  logic [DW-1:0]            wdata,
    input  logic [WORDS*DW-1:0]      fuse_next,
    output logic [1:0]               ctl_cmd,
    output logic [WORDS*DW-1:0]      pgm_flat,
    output logic [WORDS*DW-1:0]      dat_flat,
    output logic [DW-1:0]            timing_q
);
    logic wr_ctl;
    logic wr_pgm;
    logic wr_tim;

    // Write strobes per region.
    always_comb begin
        wr_ctl = wr_en && (region == RG_CTL);
        wr_pgm = wr_en && (region == RG_PGM);
        wr_tim = wr_en && (region == RG_TIM);
    end

    // Command bits: loaded by a control write, otherwise cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_cmd <= '0;
        else if (wr_ctl) ctl_cmd <= {wdata[CMD_PROG_BIT], wdata[CMD_READ_BIT]};
        else             ctl_cmd <= '0;
    end

    // Timing word: plain storage.
    always_ff @(posedge clk) begin
        if (!rst_n)      timing_q <= '0;
        else if (wr_tim) timing_q <= wdata;
    end

    // Snapshot of the post-program fuse contents on a read command.
    always_ff @(posedge clk) begin
        if (!rst_n)                      dat_flat <= '0;
        else if (ctl_cmd[CMD_READ_BIT])  dat_flat <= fuse_next;
    end

    for (genvar w = 0; w < WORDS; w++) begin : g_pgm
        // Staged program word w: plain storage.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pgm_flat[w*DW +: DW] <= '0;
            else if (wr_pgm && idx == ($clog2(WORDS))'(w))
                pgm_flat[w*DW +: DW] <= wdata;
        end
    end
endmodule

// File: rtl/otp_fuse_ctrl.sv
// Top level of the one-time fuse controller.
// Decodes the bus, drives the register file and fuse array, registers
// read data and the error pulse. Assumes one access per cycle; a read
// and a write in the same cycle are both served.
module otp_fuse_ctrl
    import otp_fuse_pkg::*;
#(
    parameter int AW    = 7,
    parameter int DW    = 32,
    parameter int WORDS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [DW/8-1:0] bus_be,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic            bus_err,
    output logic            lock_status
);
    localparam int IW = $clog2(WORDS);

    fuse_region_e          region;
    logic [IW-1:0]         idx;
    logic                  acc_ok;
    logic [1:0]            ctl_cmd;
    logic [WORDS*DW-1:0]   pgm_flat;
    logic [WORDS*DW-1:0]   dat_flat;
    logic [WORDS*DW-1:0]   fuse_flat;
    logic [WORDS*DW-1:0]   fuse_next;
    logic [DW-1:0]         timing_q;
    logic                  locked;
    logic [DW-1:0]         rd_val;

    otp_addr_decode #(.AW(AW), .DW(DW), .WORDS(WORDS)) u_dec (
        .addr   (bus_addr),
        .be     (bus_be),
        .region (region),
        .idx    (idx),
        .acc_ok (acc_ok)
    );

    otp_reg_file #(.DW(DW), .WORDS(WORDS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr && acc_ok),
        .region    (region),
        .idx       (idx),
        .wdata     (bus_wdata),
        .fuse_next (fuse_next),
        .ctl_cmd   (ctl_cmd),
        .pgm_flat  (pgm_flat),
        .dat_flat  (dat_flat),
        .timing_q  (timing_q)
    );

    otp_fuse_array #(.DW(DW), .WORDS(WORDS)) u_fuse (
        .clk       (clk),
        .rst_n     (rst_n),
        .do_prog   (ctl_cmd[CMD_PROG_BIT]),
        .pgm_flat  (pgm_flat),
        .fuse_flat (fuse_flat),
        .fuse_next (fuse_next),
        .locked    (locked)
    );

    // Read multiplexer over the register regions.
    always_comb begin
        case (region)
            RG_CTL:  rd_val = DW'(ctl_cmd);
            RG_DAT:  rd_val = dat_flat[idx*DW +: DW];
            RG_PGM:  rd_val = pgm_flat[idx*DW +: DW];
            RG_TIM:  rd_val = timing_q;
            default: rd_val = '0;
        endcase
    end

    // Registered read data and error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            bus_rdata <= (bus_rd && acc_ok) ? rd_val : '0;
            bus_err   <= (bus_rd || bus_wr) && !acc_ok;
        end
    end

    // Lock status follows the lock fuse.
    always_comb lock_status = locked;
endmodule

// File: rtl/otp_fuse_ctrl_sva.sv
// Checker for the fuse controller, attached to the top by bind.
// Relates bus ports, fuse state and command bits over time.
module otp_fuse_ctrl_sva #(
    parameter int AW    = 7,
    parameter int DW    = 32,
    parameter int WORDS = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [AW-1:0]       bus_addr,
    input logic                bus_wr,
    input logic                bus_rd,
    input logic [DW/8-1:0]     bus_be,
    input logic [DW-1:0]       bus_rdata,
    input logic                bus_err,
    input logic                lock_status,
    input logic [WORDS*DW-1:0] fuse_flat,
    input logic [1:0]          ctl_cmd
);
    // R4: no fuse bit ever goes from 1 back to 0.
    p_fuse_monotonic_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((~fuse_flat & $past(fuse_flat)) == '0));

    // R5: while locked, the array is frozen and stays locked.
    p_lock_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lock_status |=> (fuse_flat == $past(fuse_flat)) && lock_status);

    // R2: no read request means zero read data next cycle.
    p_rdata_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));

    // R10: partial or misaligned accesses raise the error pulse.
    p_bad_access_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_wr || bus_rd) && ((bus_be != '1) || (bus_addr[1:0] != 2'b00)))
        |=> bus_err);

    // R10: no access means no error pulse next cycle.
    p_err_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr || bus_rd) |=> !bus_err);

    // R9: command bits clear unless the control word is written again.
    p_ctl_selfclear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == '0 && bus_be == '1) |=> (ctl_cmd == 2'b00));
endmodule

bind otp_fuse_ctrl otp_fuse_ctrl_sva #(.AW(AW), .DW(DW), .WORDS(WORDS)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_be      (bus_be),
    .bus_rdata   (bus_rdata),
    .bus_err     (bus_err),
    .lock_status (lock_status),
    .fuse_flat   (fuse_flat),
    .ctl_cmd     (ctl_cmd)
);

// File: tb/otp_fuse_ctrl_test.sv
// Bench for the fuse controller: a behavioural model runs beside the
// design and every output is compared each clock.
module otp_fuse_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_be = 4'hF;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        lock_status;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Model state.
    logic [31:0] m_fuse [8];
    logic [31:0] m_dat  [8];
    logic [31:0] m_pgm  [8];
    logic [31:0] m_tim;
    logic [1:0]  m_ctl;
    logic [31:0] e_rdata;
    logic        e_err;

    always #10 clk = ~clk;

    otp_fuse_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .lock_status(lock_status)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit valid_acc(logic [6:0] a, logic [3:0] be);
        int o = int'(a);
        if (be != 4'hF || (o % 4) != 0) return 0;
        return (o == 0) || (o >= 8 && o <= 'h44) || (o == 'h7C);
    endfunction

    function automatic logic [31:0] model_read(logic [6:0] a);
        int o = int'(a);
        if (o == 0) return {30'd0, m_ctl};
        if (o >= 8 && o <= 'h24) return m_dat[(o - 8) / 4];
        if (o >= 'h28 && o <= 'h44) return m_pgm[(o - 'h28) / 4];
        if (o == 'h7C) return m_tim;
        return 0;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 8; i++) begin
            m_fuse[i] = 0; m_dat[i] = 0; m_pgm[i] = 0;
        end
        m_tim = 0; m_ctl = 0; e_rdata = 0; e_err = 0;
    endtask

    // Advance the model by one edge using the inputs applied this cycle.
    task automatic model_step();
        bit ok = valid_acc(bus_addr, bus_be);
        e_rdata = (bus_rd && ok) ? model_read(bus_addr) : 32'd0;
        e_err   = (bus_rd || bus_wr) && !ok;
        if (m_ctl[1] && !m_fuse[7][31])
            for (int i = 0; i < 8; i++) m_fuse[i] = m_fuse[i] | m_pgm[i];
        if (m_ctl[0])
            for (int i = 0; i < 8; i++) m_dat[i] = m_fuse[i];
        m_ctl = (bus_wr && ok && bus_addr == 0) ? bus_wdata[1:0] : 2'b00;
        if (bus_wr && ok) begin
            if (bus_addr >= 'h28 && bus_addr <= 'h44)
                m_pgm[(int'(bus_addr) - 'h28) / 4] = bus_wdata;
            else if (bus_addr == 'h7C)
                m_tim = bus_wdata;
        end
    endtask

    // One bus cycle: drive, clock, update model, compare at the negedge.
    task automatic cyc(string tag, bit wr, bit rd, logic [6:0] a,
                       logic [31:0] d, logic [3:0] be = 4'hF);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; bus_be = be;
        @(posedge clk);
        model_step();
        @(negedge clk);
        bus_wr = 0; bus_rd = 0;
        chk({tag, " rdata"}, bus_rdata, e_rdata);
        chk({tag, " err"}, {31'd0, bus_err}, {31'd0, e_err});
        chk({tag, " lock"}, {31'd0, lock_status}, {31'd0, m_fuse[7][31]});
    endtask

    task automatic wr(string tag, logic [6:0] a, logic [31:0] d);
        cyc(tag, 1, 0, a, d);
    endtask

    task automatic rd(string tag, logic [6:0] a);
        cyc(tag, 0, 1, a, 0);
    endtask

    task automatic idle(string tag);
        cyc(tag, 0, 0, 0, 0);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        chk("R1 reset rdata", bus_rdata, 0);
        chk("R1 reset err", {31'd0, bus_err}, 0);
        chk("R1 reset lock", {31'd0, lock_status}, 0);
        rst_n = 1;
        idle("R1 idle");
        // R1/R2: every mapped register reads zero
        rd("R1 ctl", 0);
        for (int i = 0; i < 8; i++) rd("R1 dat", 7'(8 + 4 * i));
        for (int i = 0; i < 8; i++) rd("R1 pgm", 7'('h28 + 4 * i));
        rd("R1 tim", 'h7C);

        // R3: program words and timing hold written values
        for (int i = 0; i < 8; i++) wr("R3 pgm wr", 7'('h28 + 4 * i), 32'h1111_0000 * (i + 1) + i);
        wr("R3 tim wr", 'h7C, 32'hCAFE_F00D);
        for (int i = 0; i < 8; i++) rd("R3 pgm rd", 7'('h28 + 4 * i));
        rd("R3 tim rd", 'h7C);
        chk("R3 tim explicit", bus_rdata, 32'hCAFE_F00D);

        // R8: data writes ignored
        wr("R8 dat wr", 'h08, 32'hFFFF_FFFF);
        wr("R8 dat wr", 'h24, 32'h1234_5678);
        rd("R8 dat rd", 'h08);
        chk("R8 dat0 explicit", bus_rdata, 0);
        rd("R8 dat rd", 'h24);

        // R10: reserved, unmapped, misaligned and partial accesses
        wr("R10 rsv04", 'h04, 32'hDEAD_BEEF);
        rd("R10 rsv04 rd", 'h04);
        chk("R10 err explicit", {31'd0, bus_err}, 1);
        wr("R10 rsv48", 'h48, 32'h1);
        rd("R10 rsv78", 'h78);
        wr("R10 misaligned", 'h2A, 32'hFFFF_FFFF);
        cyc("R10 partial wr", 1, 0, 'h28, 32'h0, 4'h3);
        cyc("R10 partial rd", 0, 1, 'h7C, 32'h0, 4'hE);
        cyc("R10 partial ctl", 1, 0, 'h00, 32'h3, 4'h1);
        idle("R10 idle");
        rd("R10 pgm0 intact", 'h28);
        chk("R10 pgm0 explicit", bus_rdata, 32'h1111_0000);
        rd("R10 dat0 intact", 'h08);

        // R9: command bits visible one cycle, then clear
        wr("R9 ctl wr", 0, 32'hFFFF_FFFD);
        rd("R9 ctl rd1", 0);
        chk("R9 ctl pending", bus_rdata, 1);
        rd("R9 ctl rd2", 0);
        chk("R9 ctl cleared", bus_rdata, 0);

        // R4/R6: program then snapshot
        for (int i = 0; i < 8; i++) wr("R4 stage", 7'('h28 + 4 * i), 32'h0000_00F0 << i);
        wr("R4 prog", 0, 2);
        idle("R4 idle");
        wr("R6 read", 0, 1);
        idle("R6 idle");
        for (int i = 0; i < 8; i++) rd("R6 dat", 7'(8 + 4 * i));
        rd("R6 dat1", 'h0C);
        chk("R6 dat1 explicit", bus_rdata, 32'h0000_01E0);

        // R4: second pass with fewer bits must not clear anything
        for (int i = 0; i < 8; i++) wr("R4 stage2", 7'('h28 + 4 * i), 32'h0000_0001);
        wr("R4 prog2", 0, 2);
        wr("R6 read2", 0, 1);
        idle("R6 idle2");
        rd("R4 dat0", 'h08);
        chk("R4 dat0 explicit", bus_rdata, 32'h0000_00F1);

        // R7: combined command programs first
        wr("R7 stage", 'h2C, 32'hA500_0000);
        wr("R7 both", 0, 3);
        idle("R7 idle");
        rd("R7 dat1", 'h0C);
        chk("R7 dat1 explicit", bus_rdata, 32'hA500_01E1);

        // R5: blow the lock fuse
        for (int i = 0; i < 8; i++) wr("R5 clear", 7'('h28 + 4 * i), 0);
        wr("R5 stage", 'h44, 32'h8000_0000);
        wr("R5 prog", 0, 2);
        idle("R5 idle");
        chk("R5 lock set", {31'd0, lock_status}, 1);
        // R5: later programming is refused
        for (int i = 0; i < 8; i++) wr("R5 stage2", 7'('h28 + 4 * i), 32'hFFFF_FFFF);
        wr("R5 prog refused", 0, 3);
        idle("R5 idle2");
        for (int i = 0; i < 8; i++) rd("R5 dat", 7'(8 + 4 * i));
        rd("R5 dat0", 'h08);
        chk("R5 dat0 explicit", bus_rdata, 32'h0000_00F1);
        rd("R5 dat7", 'h24);
        chk("R5 dat7 explicit", bus_rdata, 32'h8000_7801);

        // R2: simultaneous read and write serve the old value
        cyc("R2 rw same", 1, 1, 'h7C, 32'h5555_AAAA);
        chk("R2 old value", bus_rdata, 32'hCAFE_F00D);
        rd("R2 new value", 'h7C);
        idle("R2 idle");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule